// File: doc/BRIEF.md
# Touch Calibration Error Checker

This block grades a touch-panel calibration once its coefficients have been computed elsewhere. Software or a sequencer streams in the calibration set one pair at a time. Each pair holds a target screen coordinate and the coordinate that the computed calibration produces for the raw touch recorded at that target. For every pair the block forms the squared Euclidean distance in screen units. It keeps the largest such distance seen in the set. After the last pair it compares that worst-case figure with a programmable bound and reports pass or fail.

A set has a fixed length of five pairs (parameter `NUM_PTS`). The first pair is always the screen centre. A pulse on `set_start_i` opens a new set and discards any set that is partly delivered. The block tracks which pair it expects next on `pt_idx_o`. When the result is posted, that index returns to zero, the centre point. A failing result also raises `retry_o`, so the sequence can go back to the centre and collect the set again.

Top module: `tcal_err_check`

## Requirements
- R1: The error of one pair is (tx-mx)^2 + (ty-my)^2, with coordinates as signed two's-complement values. No square root is taken.
- R2: The result `max_err_o` is the largest per-pair error in the set. It is not the sum or the mean of the errors.
- R3: `pass_o` is 1 exactly when `max_err_o` is less than or equal to `thresh_i`, sampled in the cycle the last pair is accepted. An error equal to the bound passes. Changing `thresh_i` between sets changes the verdict for the same data.
- R4: `done_o` is high for exactly one cycle: the cycle after the fifth pair of a set is accepted. `pass_o`, `retry_o` and `max_err_o` are valid in that cycle, and `max_err_o` holds its value until the next result.
- R5: A pair is accepted when `pt_valid_i` and `pt_ready_o` are both 1. `pt_ready_o` is 0 only in a cycle where `set_start_i` is 1. No pair is taken when `pt_valid_i` is 0.
- R6: `set_start_i` clears the running maximum and the pair counter, so `pt_idx_o` is 0 in the next cycle. If the pulse arrives mid-set, the partial set produces no `done_o`.
- R7: `pt_idx_o` gives the index (0 = centre) of the next pair expected. It advances by one per accepted pair and returns to 0 after the fifth pair.
- R8: `retry_o` equals `done_o` AND NOT `pass_o`. A failing set therefore sends the sequence back to the centre point.
- R9: At the extremes (target -2048 and mapped +2047 on both axes) the error is 33538050. This value is reported exactly and does not wrap in the 26-bit result.
- R10: After reset, `done_o`, `pass_o`, `retry_o`, `max_err_o` and `pt_idx_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_start_i | input | 1 | Opens a new set; abandons a partial one |
| pt_valid_i | input | 1 | A pair is presented |
| pt_ready_o | output | 1 | Block can take a pair this cycle |
| tgt_x_i | input | COORD_W | Target x, signed |
| tgt_y_i | input | COORD_W | Target y, signed |
| map_x_i | input | COORD_W | Mapped x, signed |
| map_y_i | input | COORD_W | Mapped y, signed |
| thresh_i | input | 2*COORD_W+2 | Maximum allowed squared error |
| pt_idx_o | output | clog2(NUM_PTS) | Index of next expected pair |
| done_o | output | 1 | One-cycle result strobe |
| pass_o | output | 1 | Set within bound |
| retry_o | output | 1 | Set failed; restart from centre |
| max_err_o | output | 2*COORD_W+2 | Worst squared error of the set |

## Verification
The bench builds the block with its defaults: 12-bit coordinates and five pairs per set, which gives a 26-bit error path. At this width the full-scale corner, a 4095 offset on both axes, is reachable and shows that the error does not wrap. With five pairs, the sets can mix small errors whose sum exceeds the bound while no single error does, so the maximum measure is told apart from a sum. Boundary sets put the worst error exactly at the bound and one above it, and mid-set start pulses check that abandoned sets stay silent.

// File: rtl/tcal_pkg.sv
package tcal_pkg;
   localparam int DEF_COORD_W = 12;
   localparam int DEF_NUM_PTS = 5;

   // squared-distance width for a given coordinate width:
   // |diff| fits COORD_W bits, square 2*COORD_W, sum of two adds 1, plus guard
   function automatic int err_width(input int coord_w);
      return 2 * coord_w + 2;
   endfunction
endpackage

// File: rtl/tcal_sqdist.sv
module tcal_sqdist #(
   parameter int COORD_W = tcal_pkg::DEF_COORD_W,
   localparam int ERR_W  = tcal_pkg::err_width(COORD_W)
) (
   input  logic signed [COORD_W-1:0] tgt_x,
   input  logic signed [COORD_W-1:0] tgt_y,
   input  logic signed [COORD_W-1:0] map_x,
   input  logic signed [COORD_W-1:0] map_y,
   output logic        [ERR_W-1:0]   err
);
   localparam int SQ_W = 2 * COORD_W;

   logic signed [COORD_W-1:0] tgt_v [2];
   logic signed [COORD_W-1:0] map_v [2];
   logic        [SQ_W-1:0]    sq_v  [2];

   assign tgt_v[0] = tgt_x;
   assign tgt_v[1] = tgt_y;
   assign map_v[0] = map_x;
   assign map_v[1] = map_y;

   for (genvar a = 0; a < 2; a++) begin : g_axis
      logic signed [COORD_W:0] diff;
      logic        [COORD_W:0] mag_full;
      logic        [COORD_W-1:0] mag;
      assign diff     = {tgt_v[a][COORD_W-1], tgt_v[a]} - {map_v[a][COORD_W-1], map_v[a]};
      assign mag_full = diff[COORD_W] ? -diff : diff;
      assign mag      = mag_full[COORD_W-1:0];
      assign sq_v[a]  = SQ_W'(mag) * SQ_W'(mag);
   end

   assign err = ERR_W'(sq_v[0]) + ERR_W'(sq_v[1]);

   // R1: the sum can never be smaller than either axis term (no wrap)
   always_comb begin
      assert_sum_covers_axes_R1: assert (err >= ERR_W'(sq_v[0]) && err >= ERR_W'(sq_v[1]));
   end
endmodule

// File: rtl/tcal_max_track.sv
module tcal_max_track #(
   parameter int NUM_PTS = tcal_pkg::DEF_NUM_PTS,
   parameter int ERR_W   = tcal_pkg::err_width(tcal_pkg::DEF_COORD_W),
   localparam int IDX_W  = (NUM_PTS > 1) ? $clog2(NUM_PTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             accept,
   input  logic [ERR_W-1:0] err,
   output logic [IDX_W-1:0] idx,
   output logic             last,
   output logic [ERR_W-1:0] final_max
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PTS - 1);

   logic [ERR_W-1:0] run_max;

   assign last      = accept && (idx == LAST_IDX);
   assign final_max = (err > run_max) ? err : run_max;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx     <= '0;
         run_max <= '0;
      end else if (clear || last) begin
         idx     <= '0;
         run_max <= '0;
      end else if (accept) begin
         idx     <= idx + 1'b1;
         run_max <= final_max;
      end
   end

   assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (idx == '0 && run_max == '0));
   assert_idx_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST_IDX);
   assert_max_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !clear && !last) |=> (run_max >= $past(run_max) && run_max >= $past(err)));
endmodule

// File: rtl/tcal_err_check.sv
module tcal_err_check #(
   parameter int COORD_W = tcal_pkg::DEF_COORD_W,
   parameter int NUM_PTS = tcal_pkg::DEF_NUM_PTS,
   localparam int ERR_W  = tcal_pkg::err_width(COORD_W),
   localparam int IDX_W  = (NUM_PTS > 1) ? $clog2(NUM_PTS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      set_start_i,
   input  logic                      pt_valid_i,
   output logic                      pt_ready_o,
   input  logic signed [COORD_W-1:0] tgt_x_i,
   input  logic signed [COORD_W-1:0] tgt_y_i,
   input  logic signed [COORD_W-1:0] map_x_i,
   input  logic signed [COORD_W-1:0] map_y_i,
   input  logic        [ERR_W-1:0]   thresh_i,
   output logic        [IDX_W-1:0]   pt_idx_o,
   output logic                      done_o,
   output logic                      pass_o,
   output logic                      retry_o,
   output logic        [ERR_W-1:0]   max_err_o
);
   if (COORD_W < 2 || COORD_W > 15) begin : g_bad_coord_w
      $error("tcal_err_check: COORD_W must be within 2..15");
   end
   if (NUM_PTS < 2) begin : g_bad_num_pts
      $error("tcal_err_check: NUM_PTS must be at least 2");
   end

   logic             accept;
   logic             last;
   logic [ERR_W-1:0] pt_err;
   logic [ERR_W-1:0] final_max;
   logic             verdict;

   assign pt_ready_o = !set_start_i;
   assign accept     = pt_valid_i && pt_ready_o;
   assign verdict    = (final_max <= thresh_i);

   tcal_sqdist #(.COORD_W(COORD_W)) u_dist (
      .tgt_x (tgt_x_i),
      .tgt_y (tgt_y_i),
      .map_x (map_x_i),
      .map_y (map_y_i),
      .err   (pt_err)
   );

   tcal_max_track #(.NUM_PTS(NUM_PTS), .ERR_W(ERR_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (set_start_i),
      .accept    (accept),
      .err       (pt_err),
      .idx       (pt_idx_o),
      .last      (last),
      .final_max (final_max)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o    <= 1'b0;
         pass_o    <= 1'b0;
         retry_o   <= 1'b0;
         max_err_o <= '0;
      end else begin
         done_o  <= last;
         retry_o <= last && !verdict;
         if (last) begin
            pass_o    <= verdict;
            max_err_o <= final_max;
         end
      end
   end

   assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_start_blocks_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_start_i |=> !done_o);
   assert_ready_only_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pt_ready_o |-> set_start_i);
   assert_verdict_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pass_o == (max_err_o <= $past(thresh_i))));
   assert_retry_on_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
      retry_o |-> (done_o && !pass_o));
   assert_back_to_centre_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pt_idx_o == '0));
   assert_result_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(max_err_o));
endmodule

// File: tb/tcal_err_check_tb.sv
module tcal_err_check_tb_top;
   localparam int CW = 12;
   localparam int NP = 5;
   localparam int EW = 2 * CW + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic set_start = 1'b0;
   logic pt_valid = 1'b0;
   logic pt_ready;
   logic signed [CW-1:0] tx = '0, ty = '0, mx = '0, my = '0;
   logic [EW-1:0] thresh = EW'(5);
   logic [2:0] pt_idx;
   logic done, pass, retry;
   logic [EW-1:0] max_err;

   int n_tests = 0;
   int n_fail  = 0;
   logic [EW:0] exp_q [$];   // {pass, max_err}
   logic finished = 1'b0;

   always #10 clk = ~clk;    // 50 MHz

   tcal_err_check #(.COORD_W(CW), .NUM_PTS(NP)) dut_i (
      .clk(clk), .rst_n(rst_n), .set_start_i(set_start), .pt_valid_i(pt_valid),
      .pt_ready_o(pt_ready), .tgt_x_i(tx), .tgt_y_i(ty), .map_x_i(mx), .map_y_i(my),
      .thresh_i(thresh), .pt_idx_o(pt_idx), .done_o(done), .pass_o(pass),
      .retry_o(retry), .max_err_o(max_err)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint sqd(input int a, input int b, input int c, input int d);
      return longint'(a - c) * (a - c) + longint'(b - d) * (b - d);
   endfunction

   // monitor: pops the scoreboard on each result strobe
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected done", 1, 0);
         end else begin
            logic [EW:0] e;
            e = exp_q.pop_front();
            check(max_err == e[EW-1:0], "R2 max_err", max_err, e[EW-1:0]);
            check(pass == e[EW], "R3 pass", pass, e[EW]);
            check(retry == !e[EW], "R8 retry", retry, !e[EW]);
            check(pt_idx == 0, "R7 idx back to centre", pt_idx, 0);
         end
      end
   end

   task automatic pulse_start();
      @(negedge clk);
      set_start = 1'b1;
      pt_valid  = 1'b1;   // presented with start: must not be taken (R5)
      #1;
      check(pt_ready == 1'b0, "R5 ready low on start", pt_ready, 0);
      @(negedge clk);
      set_start = 1'b0;
      pt_valid  = 1'b0;
      check(pt_idx == 0, "R6 start clears idx", pt_idx, 0);
   endtask

   // drive n pairs; when n == NP, push the expected verdict
   task automatic drive(input int t[NP][2], input int m[NP][2], input int n,
                        input longint thr, input int gap);
      longint worst = 0;
      thresh = EW'(thr);
      for (int i = 0; i < n; i++) begin
         longint e = sqd(t[i][0], t[i][1], m[i][0], m[i][1]);
         if (e > worst) worst = e;
         if (i == n - 1 && n == NP) exp_q.push_back({(worst <= thr), EW'(worst)});
         @(negedge clk);
         tx = CW'(t[i][0]); ty = CW'(t[i][1]);
         mx = CW'(m[i][0]); my = CW'(m[i][1]);
         pt_valid = 1'b1;
         @(negedge clk);
         pt_valid = 1'b0;
         check(pt_idx == 3'((i + 1) % NP), "R7 idx advance", pt_idx, (i + 1) % NP);
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check(pt_idx == 3'((i + 1) % NP), "R5 no take without valid", pt_idx, (i + 1) % NP);
         end
      end
   endtask

   int T [NP][2] = '{'{320,240}, '{128,96}, '{128,384}, '{512,384}, '{512,96}};

   initial begin
      int m1 [NP][2] = '{'{394,244}, '{73,111}, '{251,343}, '{384,413}, '{499,89}};
      int m2 [NP][2] = '{'{321,242}, '{130,97}, '{128,384}, '{513,385}, '{512,97}};
      int m3 [NP][2] = '{'{320,240}, '{132,96}, '{128,385}, '{510,384}, '{512,96}};
      int te [NP][2] = '{'{-2048,-2048}, '{0,0}, '{0,0}, '{0,0}, '{0,0}};
      int me [NP][2] = '{'{2047,2047}, '{1,0}, '{0,0}, '{0,0}, '{0,0}};
      repeat (3) @(negedge clk);
      check(done == 0 && pass == 0 && retry == 0, "R10 reset flags", done, 0);
      check(max_err == 0 && pt_idx == 0, "R10 reset values", max_err, 0);
      check(pt_ready == 1, "R10 ready after reset", pt_ready, 1);
      rst_n = 1'b1;

      pulse_start();
      drive(T, m1, NP, 5, 0);          // R1 large errors, fails, R8 retry
      pulse_start();
      drive(T, m2, NP, 5, 1);          // R2 sum 13 > 5 but max 5 == bound: pass (R3)
      pulse_start();
      drive(T, m2, NP, 4, 0);          // R3 one below: fail
      pulse_start();
      drive(T, m3, NP, 5, 0);          // R3 max 16 fails at 5
      pulse_start();
      drive(T, m3, NP, 16, 2);         // R3 reprogrammed to 0x10: passes
      pulse_start();
      drive(te, me, NP, 5, 0);         // R9 full-scale error 33538050
      // R6 abandoned set: three bad pairs, then restart, then a clean set
      pulse_start();
      drive(T, m1, 3, 5, 0);
      pulse_start();
      drive(T, m2, NP, 5, 0);
      // R4 back-to-back sets without start pulse
      drive(T, m3, NP, 16, 0);
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
      check(max_err == EW'(16), "R4 max_err held", max_err, 16);
      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (20000) @(posedge clk);
            check(1'b0, "watchdog", 0, 1);
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule